// File: doc/BRIEF.md
# Key-Unlocked Diagnostic Control Register

This block holds the diagnostic control and status word that a host uses to manage an embedded controller's processor. Host writes to the diagnostic word are ignored unless a write-enable status bit is set. The host sets that bit by writing a fixed sequence of key bytes, in order, to a separate key register. Any write of a wrong value to the key register clears the bit at once and restarts the sequence.

The word also holds two sticky flags. One reports a bad boot-image signature. The other reports reset history. A bad-signature report from the boot logic also sets a hold bit that keeps the processor in reset. The flag and the hold bit each stay set until the host clears them. A boot-inhibit bit, while set, stops the processor from booting after a reset.

Access is a plain register port: address, write data, a single-cycle write strobe, and read data that is decoded combinationally from the address. Event inputs are single-cycle pulses in the block's clock domain.

Top module: `diag_ctl_reg`

## Requirements
- R1: After power-on reset the diagnostic word at offset 0x08 reads 0x10, meaning only reset history (bit 4) is set. The write-enable bit (bit 7) is clear, and `cpu_hold` and `boot_inhibit` are low.
- R2: While bit 7 is clear, a write to offset 0x08 changes no bit of the diagnostic word and neither output.
- R3: Bit 7 is set by the fifth of five writes to the key register at offset 0x04 with the full words 0x3C, 0xA5, 0x0F, 0x96 and 0x5A, in that order. The earlier steps alone do not set it.
- R4: A key-register write that differs from the expected word clears bit 7 from the next cycle and returns the sequence to its first step. Correct words do not clear bit 7.
- R5: While writes are enabled, bit 1 is host-writable and drives `cpu_hold`, and bit 3 is host-writable and drives `boot_inhibit`.
- R6: While writes are enabled, writing one to bit 5 clears the bad-signature flag (bit 2). Bit 5 always reads zero.
- R7: A `evt_bad_sig` pulse sets both bit 2 and bit 1.
- R8: Bit 2 and bit 1 stay set until the host clears each of them; clearing one leaves the other set.
- R9: A `evt_bus_rst` or `evt_test_rst` pulse sets bit 4. While writes are enabled, writing one to bit 4 clears it.
- R10: An event arriving in the same cycle as a host clear wins, and the affected bits stay set.
- R11: Bits 31:8, 6 and 0 of the diagnostic word read zero, and writes to bit 7 are ignored. The key register and all unmapped offsets read zero.
- R12: Asserting `rst_n` at any time returns every bit to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_bad_sig | input | 1 | Boot logic found a bad image signature |
| evt_bus_rst | input | 1 | Host bus reset occurred |
| evt_test_rst | input | 1 | Test reset occurred |
| cpu_hold | output | 1 | Holds the embedded processor in reset |
| boot_inhibit | output | 1 | Stops the processor booting after reset |

## Verification
The bench aborts the key sequence after each possible count of correct words. A design that fails to revoke the enable would leave bit 7 set. A design that fails to restart the sequence would unlock on a shortened replay after a mismatch, and the bench checks for that too.

It fires a bad-signature event together with a host clear in the same cycle, which catches a design that lets the clear win. It also clears the flag and the hold bit separately, which catches a design that ties them together.

Locked writes and all-ones writes test the gating and the reserved bits. A design that leaks either would show changed outputs or stray read-back bits.

// File: rtl/diag_reg_pkg.sv
package diag_reg_pkg;
  localparam int BIT_HOLD    = 1;
  localparam int BIT_BADSIG  = 2;
  localparam int BIT_INHIBIT = 3;
  localparam int BIT_HIST    = 4;
  localparam int BIT_CLRBAD  = 5;
  localparam int BIT_WEN     = 7;

  typedef struct packed {
    logic clr_bad;
    logic clr_hist;
    logic inhibit;
    logic hold;
  } diag_wr_t;

  typedef struct packed {
    logic wen;
    logic hist;
    logic inhibit;
    logic badsig;
    logic hold;
  } diag_state_t;
endpackage

// File: rtl/key_seq_tracker.sv
module key_seq_tracker #(
  parameter int DATA_W  = 32,
  parameter int KEY_LEN = 5,
  parameter logic [KEY_LEN*8-1:0] UNLOCK_KEY = 40'h5A_96_0F_A5_3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_wr,
  input  logic [DATA_W-1:0] seq_data,
  output logic              wr_en
);
  localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(KEY_LEN - 1);

  logic [STEP_W-1:0] step_q;
  logic [DATA_W-1:0] expect_w;
  logic              hit;

  always_comb begin
    expect_w = '0;
    expect_w[7:0] = UNLOCK_KEY[8*int'(step_q) +: 8];
  end

  assign hit = (seq_data == expect_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      wr_en  <= 1'b0;
    end else if (seq_wr) begin
      if (!hit) begin
        step_q <= '0;
        wr_en  <= 1'b0;
      end else if (step_q == LAST) begin
        step_q <= '0;
        wr_en  <= 1'b1;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  // R3: completing the sequence enables writes
  a_r3_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_wr && hit && step_q == LAST) |=> wr_en);
  // R3: the enable only rises on a key-register write
  a_r3_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(seq_wr));
  // R4: a wrong word revokes and restarts
  a_r4_revoke: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_wr && !hit) |=> (!wr_en && step_q == '0));
endmodule

// File: rtl/diag_flags.sv
module diag_flags
  import diag_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        diag_wr,
  input  diag_wr_t    wfld,
  input  logic        evt_bad_sig,
  input  logic        evt_hist,
  output diag_state_t st
);
  logic hold_q, bad_q, inh_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      bad_q  <= 1'b0;
      inh_q  <= 1'b0;
      hist_q <= 1'b1;
    end else begin
      if (evt_bad_sig)                    hold_q <= 1'b1;
      else if (diag_wr)                   hold_q <= wfld.hold;
      if (evt_bad_sig)                    bad_q  <= 1'b1;
      else if (diag_wr && wfld.clr_bad)   bad_q  <= 1'b0;
      if (diag_wr)                        inh_q  <= wfld.inhibit;
      if (evt_hist)                       hist_q <= 1'b1;
      else if (diag_wr && wfld.clr_hist)  hist_q <= 1'b0;
    end
  end

  assign st.wen     = 1'b0;
  assign st.hist    = hist_q;
  assign st.inhibit = inh_q;
  assign st.badsig  = bad_q;
  assign st.hold    = hold_q;

  // R7 / R10: the event sets both bits even under a clear
  a_r7_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bad_sig |=> (bad_q && hold_q));
  // R8: the flag only falls on a host write
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bad_q) |-> $past(diag_wr));
  // R8: the hold bit only falls on a host write
  a_r8_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(diag_wr));
  // R9 / R10: a reset event sets history
  a_r9_hist_set: assert property (@(posedge clk) disable iff (!rst_n)
    evt_hist |=> hist_q);
endmodule

// File: rtl/diag_ctl_reg.sv
module diag_ctl_reg
  import diag_reg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int KEY_LEN = 5,
  parameter logic [KEY_LEN*8-1:0] UNLOCK_KEY = 40'h5A_96_0F_A5_3C,
  parameter logic [ADDR_W-1:0] SEQ_OFS  = 8'h04,
  parameter logic [ADDR_W-1:0] DIAG_OFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              evt_bad_sig,
  input  logic              evt_bus_rst,
  input  logic              evt_test_rst,
  output logic              cpu_hold,
  output logic              boot_inhibit
);
  logic        seq_wr, diag_wr, wr_en;
  diag_wr_t    wfld;
  diag_state_t fst;

  assign seq_wr  = reg_we && (reg_addr == SEQ_OFS);
  assign diag_wr = reg_we && (reg_addr == DIAG_OFS) && wr_en;

  assign wfld.clr_bad  = reg_wdata[BIT_CLRBAD];
  assign wfld.clr_hist = reg_wdata[BIT_HIST];
  assign wfld.inhibit  = reg_wdata[BIT_INHIBIT];
  assign wfld.hold     = reg_wdata[BIT_HOLD];

  key_seq_tracker #(
    .DATA_W(DATA_W), .KEY_LEN(KEY_LEN), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_key (
    .clk(clk), .rst_n(rst_n), .seq_wr(seq_wr),
    .seq_data(reg_wdata), .wr_en(wr_en)
  );

  diag_flags u_flags (
    .clk(clk), .rst_n(rst_n), .diag_wr(diag_wr), .wfld(wfld),
    .evt_bad_sig(evt_bad_sig), .evt_hist(evt_bus_rst || evt_test_rst),
    .st(fst)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == DIAG_OFS) begin
      reg_rdata[BIT_WEN]     = wr_en;
      reg_rdata[BIT_HIST]    = fst.hist;
      reg_rdata[BIT_INHIBIT] = fst.inhibit;
      reg_rdata[BIT_BADSIG]  = fst.badsig;
      reg_rdata[BIT_HOLD]    = fst.hold;
    end
  end

  assign cpu_hold     = fst.hold;
  assign boot_inhibit = fst.inhibit;

  // R2: locked writes leave the outputs alone
  a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == DIAG_OFS && !wr_en && !evt_bad_sig)
      |=> ($stable(boot_inhibit) && $stable(cpu_hold)));
  // R5: outputs only change on a write or an event
  a_r5_inhibit_src: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(boot_inhibit) |-> $past(diag_wr));
endmodule

// File: tb/diag_ctl_reg_tb_top.sv
module diag_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        evt_bad_sig = 1'b0, evt_bus_rst = 1'b0, evt_test_rst = 1'b0;
  logic        cpu_hold, boot_inhibit;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  key [5] = '{8'h3C, 8'hA5, 8'h0F, 8'h96, 8'h5A};

  always #5 clk = ~clk;

  diag_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_bad_sig(evt_bad_sig),
    .evt_bus_rst(evt_bus_rst), .evt_test_rst(evt_test_rst),
    .cpu_hold(cpu_hold), .boot_inhibit(boot_inhibit)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] a,
                     input logic [31:0] mask, input logic [31:0] exp);
    reg_addr = a;
    #1;
    n_run++;
    if ((reg_rdata & mask) !== exp) begin
      n_fail++;
      $display("FAIL %s: addr %h read %h expected %h", req, a, reg_rdata & mask, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic eh, input logic ei);
    #1;
    n_run++;
    if (cpu_hold !== eh || boot_inhibit !== ei) begin
      n_fail++;
      $display("FAIL %s: hold/inhibit %b%b expected %b%b", req,
               cpu_hold, boot_inhibit, eh, ei);
    end
  endtask

  task automatic unlock();
    for (int i = 0; i < 5; i++) wr(8'h04, {24'h0, key[i]});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 8'h08, 32'hFFFF_FFFF, 32'h10);
    chk_out("R1", 1'b0, 1'b0);

    wr(8'h08, 32'h3A);
    chk("R2", 8'h08, 32'hFFFF_FFFF, 32'h10);
    chk_out("R2", 1'b0, 1'b0);

    for (int i = 0; i < 4; i++) wr(8'h04, {24'h0, key[i]});
    chk("R3", 8'h08, 32'h80, 32'h0);
    wr(8'h04, {24'h0, key[4]});
    chk("R3", 8'h08, 32'hFFFF_FFFF, 32'h90);

    wr(8'h08, 32'h0A);
    chk("R5", 8'h08, 32'hFFFF_FFFF, 32'h9A);
    chk_out("R5", 1'b1, 1'b1);
    wr(8'h08, 32'h08);
    chk_out("R5", 1'b0, 1'b1);

    wr(8'h08, 32'h18);
    chk("R9", 8'h08, 32'hFFFF_FFFF, 32'h88);
    @(negedge clk); evt_bus_rst = 1'b1; @(negedge clk); evt_bus_rst = 1'b0;
    chk("R9", 8'h08, 32'hFFFF_FFFF, 32'h98);
    wr(8'h08, 32'h18);
    @(negedge clk); evt_test_rst = 1'b1; @(negedge clk); evt_test_rst = 1'b0;
    chk("R9", 8'h08, 32'hFFFF_FFFF, 32'h98);
    wr(8'h08, 32'h18);
    chk("R9", 8'h08, 32'hFFFF_FFFF, 32'h88);

    @(negedge clk); evt_bad_sig = 1'b1; @(negedge clk); evt_bad_sig = 1'b0;
    chk("R7", 8'h08, 32'hFFFF_FFFF, 32'h8E);
    chk_out("R7", 1'b1, 1'b1);
    wr(8'h08, 32'h2A);
    chk("R6", 8'h08, 32'hFFFF_FFFF, 32'h8A);
    chk_out("R8", 1'b1, 1'b1);
    wr(8'h08, 32'h08);
    chk("R8", 8'h08, 32'hFFFF_FFFF, 32'h88);
    @(negedge clk); evt_bad_sig = 1'b1; @(negedge clk); evt_bad_sig = 1'b0;
    wr(8'h08, 32'h0A);
    chk("R8", 8'h08, 32'hFFFF_FFFF, 32'h8E);
    wr(8'h08, 32'h28);

    @(negedge clk);
    reg_addr = 8'h08; reg_wdata = 32'h38; reg_we = 1'b1;
    evt_bad_sig = 1'b1; evt_bus_rst = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; evt_bad_sig = 1'b0; evt_bus_rst = 1'b0;
    chk("R10", 8'h08, 32'hFFFF_FFFF, 32'h9E);
    wr(8'h08, 32'h38);
    chk("R10", 8'h08, 32'hFFFF_FFFF, 32'h88);

    wr(8'h08, 32'hFFFF_FF7F);
    chk("R11", 8'h08, 32'hFFFF_FFFF, 32'h8A);
    chk("R11", 8'h04, 32'hFFFF_FFFF, 32'h0);
    chk("R11", 8'h0C, 32'hFFFF_FFFF, 32'h0);
    wr(8'h08, 32'h08);

    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < p; i++) wr(8'h04, {24'h0, key[i]});
      chk("R4", 8'h08, 32'h80, 32'h80);
      wr(8'h04, {24'h0, ~key[p]});
      chk("R4", 8'h08, 32'h80, 32'h0);
      wr(8'h08, 32'h0);
      chk_out("R2", 1'b0, 1'b1);
      unlock();
      chk("R3", 8'h08, 32'h80, 32'h80);
    end

    wr(8'h04, {24'h0, key[0]});
    wr(8'h04, {24'h0, key[1]});
    wr(8'h04, 32'h0000_0100);
    for (int i = 1; i < 5; i++) wr(8'h04, {24'h0, key[i]});
    chk("R4", 8'h08, 32'h80, 32'h0);

    unlock();
    wr(8'h08, 32'h0A);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R12", 8'h08, 32'hFFFF_FFFF, 32'h10);
    chk_out("R12", 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule